// File: doc/BRIEF.md
# Module Clock Stop and Reset Controller

This block gates the clocks and drives the software resets of a large set of peripheral modules. Every module owns one bit position: module n lives in bank n/32 at bit n%32. A bank holds three clock-stop words, one status word that reports the stop state seen by the module after an acknowledge delay, one reset word that is set by writing ones, and one write-only word that releases resets.

Software reaches all of this through a plain memory-mapped port: address, write data, a write strobe and combinational read data. A module's clock runs only when its bit is zero in all three stop words. Software that enables a clock polls the status word until the bit reads zero. A reset can be released no earlier than a minimum hold time after it was asserted. A release requested too early is remembered and takes effect as soon as the hold time is over.

Top module: `modgate_ctrl`

## Requirements
- R1: After reset every stop word reads all ones, every status word reads all ones, `mod_clk_en_o` is all zeros and `mod_rst_o` is all zeros. Module n maps to bit 32*b+k of both output vectors, where b=n/32 and k=n%32.
- R2: Address bits [11:8] select the register kind: 1 = main stop word, 2 = first auxiliary stop word, 3 = second auxiliary stop word, 4 = status word, 5 = reset-set word, 6 = reset-release word. Bits [7:2] select the bank and bits [1:0] must be zero.
- R3: `mod_clk_en_o` bit for a module is 1 exactly when its bit is 0 in all three stop words of its bank. It changes at the clock edge that completes the stop-word write.
- R4: A write to any stop word replaces the whole word, and a read returns the stored value.
- R5: The status word holds the OR of the three stop words as it stood ACK_LAT edges earlier. A status bit therefore reads 0 (running) ACK_LAT edges after `mod_clk_en_o` rose for that module.
- R6: A write to the reset-set word ORs the written ones into the bank's reset state, so written zeros have no effect. A read of that address returns the current reset state, which also drives `mod_rst_o`.
- R7: A write to the reset-release word releases the modules whose bits are 1. Written zeros have no effect, and the address always reads 0.
- R8: A reset bit cannot fall until HOLD_CYC+1 edges after the latest reset-set write that newly asserted any bit of that bank. A release written earlier is held pending and applied at the first allowed edge.
- R9: When a pending release is applied at the same edge as a reset-set write to the same bit, the release wins and the bit ends at 0.
- R10: A read of an unmapped address returns 0 and a write to one changes no state. Unmapped means a kind code outside 1..6, a bank index at or above NUM_BANKS, or nonzero bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one word per cycle |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| mod_clk_en_o | output | NUM_BANKS*32 | Per-module clock enable |
| mod_rst_o | output | NUM_BANKS*32 | Per-module reset, active high |

## Verification
The bench targets the edge at which a deferred release finally lands. A design that releases too early shortens the module's reset, and one that forgets the pending release leaves the module in reset forever. It also sets a bit again in the very cycle a pending release lands; a design where the set wins holds the module in reset when it should not. Another check counts the exact number of cycles between a clock enable and its status acknowledge, which catches an off-by-one acknowledge delay that would make polling software read stale state. Unmapped addresses and non-aligned offsets are also hit, because a decoder that ignores the low bits or the bank limit would corrupt a neighbouring bank.

// File: rtl/modgate_pkg.sv
package modgate_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int BANK_IDX_W = 6;
    localparam int STOP_WORDS = 3;

    typedef enum logic [3:0] {
        RGN_NONE      = 4'h0,
        RGN_STOP_MAIN = 4'h1,
        RGN_STOP_AUXA = 4'h2,
        RGN_STOP_AUXB = 4'h3,
        RGN_STATUS    = 4'h4,
        RGN_RST_SET   = 4'h5,
        RGN_RST_CLR   = 4'h6
    } region_e;

    typedef struct packed {
        logic                  hit;
        region_e               rgn;
        logic [BANK_IDX_W-1:0] bank;
    } dec_s;

    function automatic logic is_region(input logic [3:0] code);
        return (code >= 4'h1) && (code <= 4'h6);
    endfunction

    function automatic logic [WORD_W-1:0] merge_stop(input logic [STOP_WORDS-1:0][WORD_W-1:0] w);
        logic [WORD_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < STOP_WORDS; k++) acc |= w[k];
        return acc;
    endfunction

endpackage

// File: rtl/modgate_decode.sv
module modgate_decode
    import modgate_pkg::*;
#(
    parameter int NUM_BANKS = 12
) (
    input  logic [ADDR_W-1:0]                     addr_i,
    input  logic                                  we_i,
    output dec_s                                  dec_o,
    output logic [STOP_WORDS-1:0][NUM_BANKS-1:0]  stop_we_o,
    output logic [NUM_BANKS-1:0]                  set_we_o,
    output logic [NUM_BANKS-1:0]                  clr_we_o
);
    localparam logic [BANK_IDX_W-1:0] BANK_LIMIT = BANK_IDX_W'(NUM_BANKS);

    always_comb begin
        dec_o.rgn  = region_e'(addr_i[11:8]);
        dec_o.bank = addr_i[7:2];
        dec_o.hit  = (addr_i[1:0] == 2'b00) && (addr_i[7:2] < BANK_LIMIT)
                     && is_region(addr_i[11:8]);
        if (!dec_o.hit) dec_o.rgn = RGN_NONE;
    end

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            logic sel;
            sel = we_i && dec_o.hit && (dec_o.bank == BANK_IDX_W'(b));
            stop_we_o[0][b] = sel && (dec_o.rgn == RGN_STOP_MAIN);
            stop_we_o[1][b] = sel && (dec_o.rgn == RGN_STOP_AUXA);
            stop_we_o[2][b] = sel && (dec_o.rgn == RGN_STOP_AUXB);
            set_we_o[b]     = sel && (dec_o.rgn == RGN_RST_SET);
            clr_we_o[b]     = sel && (dec_o.rgn == RGN_RST_CLR);
        end
    end

endmodule

// File: rtl/modgate_stop_bank.sv
module modgate_stop_bank
    import modgate_pkg::*;
#(
    parameter int ACK_LAT = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [STOP_WORDS-1:0]                we_i,
    input  logic [WORD_W-1:0]                    wdata_i,
    output logic [STOP_WORDS-1:0][WORD_W-1:0]    ctl_o,
    output logic [WORD_W-1:0]                    stat_o,
    output logic [WORD_W-1:0]                    run_o
);
    logic [STOP_WORDS-1:0][WORD_W-1:0] ctl_q;
    logic [ACK_LAT-1:0][WORD_W-1:0]    ack_q;
    logic [WORD_W-1:0]                 eff_stop;

    genvar gk;
    generate
        for (gk = 0; gk < STOP_WORDS; gk++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)            ctl_q[gk] <= '1;
                else if (we_i[gk])  ctl_q[gk] <= wdata_i;
            end
        end
    endgenerate

    assign eff_stop = merge_stop(ctl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= '1;
        end else begin
            ack_q[0] <= eff_stop;
            for (int i = 1; i < ACK_LAT; i++) ack_q[i] <= ack_q[i-1];
        end
    end

    assign ctl_o  = ctl_q;
    assign stat_o = ack_q[ACK_LAT-1];
    assign run_o  = ~eff_stop;

    // R4: stop words change only on a decoded write
    assert_stop_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (we_i == '0) |=> $stable(ctl_q));

    // R5: first acknowledge stage captures the run state of the previous cycle
    assert_ack_follow_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ack_q[0] == ~$past(run_o)));

endmodule

// File: rtl/modgate_rst_bank.sv
module modgate_rst_bank
    import modgate_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_we_i,
    input  logic                 clr_we_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [WORD_W-1:0]    rst_o
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC);

    logic [WORD_W-1:0] rst_q, pend_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] set_bits, clr_bits, pend_all;
    logic              hold_done, fresh_set;

    assign set_bits  = set_we_i ? wdata_i : '0;
    assign clr_bits  = clr_we_i ? wdata_i : '0;
    assign pend_all  = pend_q | clr_bits;
    assign hold_done = (cnt_q == '0);
    assign fresh_set = |(set_bits & ~rst_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_q  <= '0;
            pend_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (hold_done) begin
                rst_q  <= (rst_q | set_bits) & ~pend_all;
                pend_q <= '0;
            end else begin
                rst_q  <= rst_q | set_bits;
                pend_q <= pend_all;
            end
            if (fresh_set)       cnt_q <= CNT_LOAD;
            else if (!hold_done) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign rst_o = rst_q;

    // R8: no reset bit falls while the hold window is still open
    assert_hold_window_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> ((rst_q & $past(rst_q)) == $past(rst_q)));

    // R6: reset bits rise only on a reset-set write
    assert_set_only_R6: assert property (@(posedge clk) disable iff (rst)
        !set_we_i |=> ((rst_q & ~$past(rst_q)) == '0));

    // R9: a pending release that lands leaves none of its bits asserted
    assert_release_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (hold_done && !clr_we_i) |=> ((rst_q & $past(pend_q)) == '0));

endmodule

// File: rtl/modgate_ctrl.sv
module modgate_ctrl
    import modgate_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int ACK_LAT   = 4,
    parameter int HOLD_CYC  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [11:0]                 bus_addr_i,
    input  logic [31:0]                 bus_wdata_i,
    input  logic                        bus_we_i,
    output logic [31:0]                 bus_rdata_o,
    output logic [NUM_BANKS*32-1:0]     mod_clk_en_o,
    output logic [NUM_BANKS*32-1:0]     mod_rst_o
);
    localparam int NUM_MODS = NUM_BANKS * WORD_W;

    dec_s                                 dec;
    logic [STOP_WORDS-1:0][NUM_BANKS-1:0] stop_we;
    logic [NUM_BANKS-1:0]                 set_we, clr_we;

    logic [STOP_WORDS-1:0][WORD_W-1:0]    ctl_rd  [NUM_BANKS];
    logic [WORD_W-1:0]                    stat_rd [NUM_BANKS];
    logic [WORD_W-1:0]                    rst_rd  [NUM_BANKS];
    logic [WORD_W-1:0]                    run_rd  [NUM_BANKS];

    modgate_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr_i    (bus_addr_i),
        .we_i      (bus_we_i),
        .dec_o     (dec),
        .stop_we_o (stop_we),
        .set_we_o  (set_we),
        .clr_we_o  (clr_we)
    );

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            logic [STOP_WORDS-1:0] bank_stop_we;
            for (genvar gk = 0; gk < STOP_WORDS; gk++) begin : g_we
                assign bank_stop_we[gk] = stop_we[gk][gb];
            end

            modgate_stop_bank #(.ACK_LAT(ACK_LAT)) u_stop (
                .clk     (clk),
                .rst     (rst),
                .we_i    (bank_stop_we),
                .wdata_i (bus_wdata_i),
                .ctl_o   (ctl_rd[gb]),
                .stat_o  (stat_rd[gb]),
                .run_o   (run_rd[gb])
            );

            modgate_rst_bank #(.HOLD_CYC(HOLD_CYC)) u_rst (
                .clk      (clk),
                .rst      (rst),
                .set_we_i (set_we[gb]),
                .clr_we_i (clr_we[gb]),
                .wdata_i  (bus_wdata_i),
                .rst_o    (rst_rd[gb])
            );

            assign mod_clk_en_o[gb*WORD_W +: WORD_W] = run_rd[gb];
            assign mod_rst_o[gb*WORD_W +: WORD_W]    = rst_rd[gb];
        end
    endgenerate

    always_comb begin
        bus_rdata_o = '0;
        if (dec.hit) begin
            unique case (dec.rgn)
                RGN_STOP_MAIN: bus_rdata_o = ctl_rd[dec.bank][0];
                RGN_STOP_AUXA: bus_rdata_o = ctl_rd[dec.bank][1];
                RGN_STOP_AUXB: bus_rdata_o = ctl_rd[dec.bank][2];
                RGN_STATUS:    bus_rdata_o = stat_rd[dec.bank];
                RGN_RST_SET:   bus_rdata_o = rst_rd[dec.bank];
                default:       bus_rdata_o = '0;
            endcase
        end
    end

    // R10: unmapped reads return zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |-> (bus_rdata_o == '0));

    // R2: a write selects at most one register of one bank
    assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stop_we, set_we, clr_we}));

    // R7: the release word never reads back a value
    assert_clear_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (dec.rgn == RGN_RST_CLR) |-> (bus_rdata_o == '0));

    initial begin
        if (NUM_MODS != NUM_BANKS * 32) $display("modgate_ctrl: width mismatch");
    end

endmodule

// File: tb/tb_modgate_ctrl.sv
module tb_modgate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 12;
    localparam int ACK  = 4;
    localparam int HOLD = 16;
    localparam int NM   = NB * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic          wr = 1'b0;
    logic [31:0]   rdata;
    logic [NM-1:0] clk_en, mrst;

    int vectors = 0;
    int fails = 0;

    logic [31:0] m_ctl  [3][NB];
    logic [31:0] m_pipe [ACK][NB];
    logic [31:0] m_rst  [NB];
    logic [31:0] m_pend [NB];
    int          m_cnt  [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    modgate_ctrl #(.NUM_BANKS(NB), .ACK_LAT(ACK), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(wr),
        .bus_rdata_o(rdata), .mod_clk_en_o(clk_en), .mod_rst_o(mrst)
    );

    task automatic chk(input string tag, input logic [NM-1:0] act, input logic [NM-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input int r, input int b);
        return {4'(r), 6'(b), 2'b00};
    endfunction

    function automatic bit tb_dec(input logic [11:0] a, output int r, output int b);
        r = int'(a[11:8]);
        b = int'(a[7:2]);
        return (a[1:0] == 2'b00) && (b < NB) && (r >= 1) && (r <= 6);
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int r, b;
        if (!tb_dec(a, r, b)) return '0;
        case (r)
            1, 2, 3: return m_ctl[r-1][b];
            4:       return m_pipe[ACK-1][b];
            5:       return m_rst[b];
            default: return '0;
        endcase
    endfunction

    function automatic string read_tag(input logic [11:0] a);
        int r, b;
        if (!tb_dec(a, r, b)) return "R10 unmapped read";
        case (r)
            1, 2, 3: return "R4 stop readback";
            4:       return "R5 status readback";
            5:       return "R6 reset readback";
            default: return "R7 release reads zero";
        endcase
    endfunction

    function automatic logic [NM-1:0] exp_en();
        logic [NM-1:0] v;
        for (int k = 0; k < NB; k++) v[k*32 +: 32] = ~(m_ctl[0][k] | m_ctl[1][k] | m_ctl[2][k]);
        return v;
    endfunction

    function automatic logic [NM-1:0] exp_rst();
        logic [NM-1:0] v;
        for (int k = 0; k < NB; k++) v[k*32 +: 32] = m_rst[k];
        return v;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NB; k++) begin
            for (int j = 0; j < 3; j++) m_ctl[j][k] = '1;
            for (int i = 0; i < ACK; i++) m_pipe[i][k] = '1;
            m_rst[k] = '0; m_pend[k] = '0; m_cnt[k] = 0;
        end
    endtask

    task automatic model_edge(input logic w, input logic [11:0] a, input logic [31:0] d);
        int r, b;
        bit ok;
        ok = tb_dec(a, r, b);
        for (int i = ACK-1; i > 0; i--)
            for (int k = 0; k < NB; k++) m_pipe[i][k] = m_pipe[i-1][k];
        for (int k = 0; k < NB; k++) m_pipe[0][k] = m_ctl[0][k] | m_ctl[1][k] | m_ctl[2][k];
        for (int k = 0; k < NB; k++) begin
            logic [31:0] sw, cw, pn;
            int nc;
            sw = (w && ok && r == 5 && b == k) ? d : '0;
            cw = (w && ok && r == 6 && b == k) ? d : '0;
            pn = m_pend[k] | cw;
            if ((sw & ~m_rst[k]) != 0) nc = HOLD;
            else if (m_cnt[k] != 0)    nc = m_cnt[k] - 1;
            else                       nc = 0;
            if (m_cnt[k] == 0) begin
                m_rst[k]  = (m_rst[k] | sw) & ~pn;
                m_pend[k] = '0;
            end else begin
                m_rst[k]  = m_rst[k] | sw;
                m_pend[k] = pn;
            end
            m_cnt[k] = nc;
        end
        if (w && ok && r >= 1 && r <= 3) m_ctl[r-1][b] = d;
    endtask

    task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = w; addr = a; wdata = d;
        #1;
        chk(read_tag(a), NM'(rdata), NM'(exp_read(a)));
        @(posedge clk);
        model_edge(w, a, d);
        #1;
        chk("R3 clock enable vector", clk_en, exp_en());
        chk("R6 R7 R8 reset vector", mrst, exp_rst());
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [NM-1:0] one_hot;
        void'($urandom(32'h1c3a_55e1));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 reset clock enables", clk_en, '0);
        chk("R1 reset module resets", mrst, '0);
        addr = mk(4, 11); #1;
        chk("R1 reset status", NM'(rdata), NM'(32'hffff_ffff));
        addr = mk(2, 0); #1;
        chk("R1 reset aux stop", NM'(rdata), NM'(32'hffff_ffff));

        // R1 R3: module 101 (bank 3, bit 5) runs only when all three words clear it
        step(1, mk(1, 3), ~(32'h1 << 5));
        step(1, mk(2, 3), ~(32'h1 << 5));
        chk("R3 still stopped by second aux word", clk_en, '0);
        step(1, mk(3, 3), ~(32'h1 << 5));
        one_hot = '0; one_hot[3*32+5] = 1'b1;
        chk("R1 module index mapping", clk_en, one_hot);

        // R5: status bit clears ACK edges after the enable rose
        for (int k = 1; k <= ACK + 1; k++) begin
            @(negedge clk); wr = 0; addr = mk(4, 3); #1;
            chk("R5 acknowledge delay", NM'(rdata[5]), NM'(k <= ACK));
            @(posedge clk); model_edge(0, mk(4, 3), 0);
        end

        // R8: early release is deferred
        step(1, mk(5, 2), 32'h1 << 7);
        step(1, mk(6, 2), 32'h1 << 7);
        for (int k = 0; k < HOLD - 1; k++) step(0, 12'h0, 0);
        chk("R8 reset held through window", NM'(mrst[2*32+7]), NM'(1));
        step(0, 12'h0, 0);
        chk("R8 deferred release lands", NM'(mrst[2*32+7]), NM'(0));

        // R9: release lands in the same edge as a set of the same bit
        step(1, mk(5, 4), 32'h1 << 9);
        step(1, mk(6, 4), 32'h1 << 9);
        for (int k = 0; k < HOLD - 1; k++) step(0, 12'h0, 0);
        step(1, mk(5, 4), 32'h1 << 9);
        chk("R9 release wins", NM'(mrst[4*32+9]), NM'(0));

        // R6 R7: zeros have no effect
        step(1, mk(5, 6), 32'h0000_00f0);
        for (int k = 0; k < HOLD + 2; k++) step(0, 12'h0, 0);
        step(1, mk(5, 6), 32'h0);
        step(1, mk(6, 6), 32'h0);
        chk("R7 zero release keeps reset", NM'(mrst[6*32 +: 32]), NM'(32'h0000_00f0));
        step(1, mk(6, 6), 32'h0000_0030);
        chk("R7 partial release", NM'(mrst[6*32 +: 32]), NM'(32'h0000_00c0));

        // R10 and R2: unmapped writes change nothing
        step(1, mk(1, 12), 32'h0);
        step(1, mk(7, 0), 32'h0);
        step(1, mk(1, 0) | 12'h1, 32'h0);
        step(1, mk(0, 1), 32'h0);
        chk("R10 unmapped writes ignored", clk_en, one_hot);

        // random traffic checked against the bench model
        for (int n = 0; n < 4000; n++) begin
            int r, b;
            logic [11:0] a;
            logic [31:0] d;
            r = int'($urandom_range(0, 7));
            b = int'($urandom_range(0, 13));
            a = mk(r, b);
            if ($urandom_range(0, 19) == 0) a[1:0] = 2'($urandom_range(1, 3));
            if (r == 5 || r == 6) d = $urandom & $urandom & $urandom;
            else                  d = $urandom | $urandom;
            step($urandom_range(0, 1) == 1, a, d);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule